// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a parallel flash bus interface and the program/erase controller of a NOR flash array. It watches write cycles, each one a single-cycle strobe carrying an address and a data byte. It recognises the coded instruction sequences that guard every operation: read/reset, signature read, program, chip erase, block erase with multi-block accumulation, erase suspend and erase resume. For each accepted instruction it emits a one-cycle command pulse with the address and data latched from the write that completed it. It also keeps the read mode that the output multiplexer of the part should use: array, signature or status.

Every instruction starts with two coded unlock writes. An erase needs a second unlock pair before its confirm write. Any deviation from the expected sequence drops the decoder back to array read. Suspend and resume are single writes. After the last block address of a block erase, a window of parameterised length stays open. Further block addresses may be added during the window, and each one restarts it. When the window closes, the erase is started. While the controller reports busy, only the suspend write is accepted.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 0 (array), cmd_valid is low, timer_expired is 1 and erase_suspended is 0.
- R2: The first unlock write is AAh at code address 5555h in word mode (byte_mode=0) or AAAAh in byte mode (byte_mode=1). The second is 55h at 2AAAh (word) or 5555h (byte). Only the low 15 address bits (word) or 16 bits (byte) are compared; higher bits are ignored.
- R3: Unlock pair then F0h at the first code address pulses cmd_op=1 (reset) and sets read_mode to 0.
- R4: Unlock pair then 90h at the first code address sets read_mode to 1 (signature) and issues no command.
- R5: Unlock pair, A0h at the first code address, then any write pulses cmd_op=2 (program) with that write's address and data, and sets read_mode to 2 (status).
- R6: Unlock pair, 80h, unlock pair again, then 10h at the first code address pulses cmd_op=3 (chip erase), marks an erase active and sets read_mode to 2.
- R7: The same erase prefix ending in 30h at any address pulses cmd_op=4 (block add) with that address and opens the erase window (timer_expired=0). Each further 30h in the window pulses cmd_op=4 and restarts the window. Other writes in the window are ignored. ERASE_WIN_CYC cycles after the last 30h write, cmd_op=5 (erase start) pulses, carrying the last block address and data, and timer_expired returns to 1.
- R8: A write with wrong data or wrong code address at any sequence step issues no command, returns read_mode to 0 and restarts sequence recognition.
- R9: While busy is high, every write other than an accepted suspend is ignored: no command, no change of read_mode or sequence state.
- R10: B0h at any address while an erase is active and not suspended pulses cmd_op=6 (suspend), even when busy, sets erase_suspended and read_mode 0. With no erase active, B0h is an invalid write.
- R11: While suspended, a complete program sequence is accepted. A single 30h at any address pulses cmd_op=7 (resume), clears erase_suspended and sets read_mode 2.
- R12: An erase_done pulse ends the active erase and clears erase_suspended one cycle later. After that, B0h is treated as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (hardware reset or power-up) |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address (word address in word mode, byte address in byte mode) |
| wr_data | input | 8 | Write data byte |
| byte_mode | input | 1 | 1 selects byte-wide code addresses |
| busy | input | 1 | Controller busy with program or erase |
| erase_done | input | 1 | Controller pulse: erase finished or aborted |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 3 | Command code (1..7, see requirements) |
| cmd_addr | output | ADDR_W | Address latched with the command |
| cmd_data | output | 8 | Data latched with the command |
| read_mode | output | 2 | 0 array, 1 signature, 2 status |
| timer_expired | output | 1 | Status bit 3: 0 while the erase window is open |
| erase_suspended | output | 1 | Erase currently suspended |

## Verification
Every write is sampled on one rising edge. Its command pulse, read_mode and erase_suspended change on that same edge, so the bench samples them at the falling edge that ends the write. The bench checks the erase start against an exact count. One falling edge after the last block-add write, plus ERASE_WIN_CYC-1 more, it checks that the window is still open with no pulse. One edge later it checks that the erase start pulse is present and the window has closed. Expected command pulses are queued before each driving write and popped by a monitor on every falling edge where cmd_valid is high. A missing or extra pulse therefore shows up as a mismatch or as an unexpected item.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   typedef enum logic [2:0] {
      OP_NONE        = 3'd0,
      OP_RESET       = 3'd1,
      OP_PROGRAM     = 3'd2,
      OP_CHIP_ERASE  = 3'd3,
      OP_BLOCK_ADD   = 3'd4,
      OP_ERASE_START = 3'd5,
      OP_SUSPEND     = 3'd6,
      OP_RESUME      = 3'd7
   } fcd_op_e;

   typedef enum logic [1:0] {
      RM_ARRAY     = 2'd0,
      RM_SIGNATURE = 2'd1,
      RM_STATUS    = 2'd2
   } fcd_rmode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNL1,
      ST_UNL2,
      ST_PROG,
      ST_ER1,
      ST_ER2,
      ST_ER3,
      ST_WIN
   } fcd_state_e;

   // data codes of the write cycles
   parameter logic [7:0] D_UNLOCK_A = 8'hAA;
   parameter logic [7:0] D_UNLOCK_B = 8'h55;
   parameter logic [7:0] D_RESET    = 8'hF0;
   parameter logic [7:0] D_AUTOSEL  = 8'h90;
   parameter logic [7:0] D_PROGRAM  = 8'hA0;
   parameter logic [7:0] D_ERASE    = 8'h80;
   parameter logic [7:0] D_CHIP     = 8'h10;
   parameter logic [7:0] D_BLOCK    = 8'h30;
   parameter logic [7:0] D_SUSPEND  = 8'hB0;

   // width of the compared code address field in word mode
   parameter int CODE_W = 15;

endpackage

// File: rtl/fcd_code_match.sv
module fcd_code_match #(
   parameter int CODE_W = 15,
   parameter logic [CODE_W:0] WORD_CODE = '0,
   parameter logic [CODE_W:0] BYTE_CODE = '0
) (
   input  logic [CODE_W:0] addr,
   input  logic            byte_mode,
   output logic            hit
);

   // byte mode carries one extra low address bit
   always_comb begin
      if (byte_mode) hit = (addr == BYTE_CODE);
      else           hit = (addr[CODE_W-1:0] == WORD_CODE[CODE_W-1:0]);
   end

endmodule

// File: rtl/fcd_erase_window.sv
module fcd_erase_window #(
   parameter int WIN_CYC = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic active,
   output logic expire
);

   localparam int CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;

   if (WIN_CYC < 2) begin : g_bad_win
      $error("fcd_erase_window: WIN_CYC must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         active <= 1'b1;
         cnt_q  <= CW'(WIN_CYC - 1);
      end else if (active) begin
         if (cnt_q == '0) active <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign expire = active && (cnt_q == '0) && !load;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W        = 19,
   parameter int ERASE_WIN_CYC = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              byte_mode,
   input  logic              busy,
   input  logic              erase_done,
   output logic              cmd_valid,
   output logic [2:0]        cmd_op,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [7:0]        cmd_data,
   output logic [1:0]        read_mode,
   output logic              timer_expired,
   output logic              erase_suspended
);

   localparam int NCODES = 2;

   if (ADDR_W < CODE_W + 2) begin : g_bad_addr
      $error("flash_cmd_decoder: ADDR_W too small for the code address field");
   end

   // code address matchers: index 0 first code address, index 1 second
   logic [NCODES-1:0] code_hit;

   for (genvar gi = 0; gi < NCODES; gi++) begin : g_code
      localparam logic [CODE_W:0] WC = (gi == 0) ? 16'h5555 : 16'h2AAA;
      localparam logic [CODE_W:0] BC = (gi == 0) ? 16'hAAAA : 16'h5555;
      fcd_code_match #(
         .CODE_W   (CODE_W),
         .WORD_CODE(WC),
         .BYTE_CODE(BC)
      ) u_match (
         .addr     (wr_addr[CODE_W:0]),
         .byte_mode(byte_mode),
         .hit      (code_hit[gi])
      );
   end

   fcd_state_e        state_q, state_d;
   fcd_rmode_e        rmode_q, rmode_d;
   fcd_op_e           op_q, op_d;
   logic              valid_q, valid_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [7:0]        data_q, data_d;
   logic              act_q, act_d;
   logic              susp_q, susp_d;
   logic              win_load, win_active, win_expire;

   fcd_erase_window #(.WIN_CYC(ERASE_WIN_CYC)) u_window (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (win_load),
      .active(win_active),
      .expire(win_expire)
   );

   logic is_susp;
   assign is_susp = wr_stb && (wr_data == D_SUSPEND) && act_q && !susp_q;

   always_comb begin
      state_d  = state_q;
      rmode_d  = rmode_q;
      op_d     = OP_NONE;
      valid_d  = 1'b0;
      addr_d   = addr_q;
      data_d   = data_q;
      act_d    = act_q;
      susp_d   = susp_q;
      win_load = 1'b0;

      if (erase_done) begin
         act_d  = 1'b0;
         susp_d = 1'b0;
      end

      if (win_expire) begin
         valid_d = 1'b1;
         op_d    = OP_ERASE_START;
         act_d   = 1'b1;
         state_d = ST_IDLE;
      end

      if (is_susp) begin
         valid_d = 1'b1;
         op_d    = OP_SUSPEND;
         addr_d  = wr_addr;
         data_d  = wr_data;
         susp_d  = 1'b1;
         rmode_d = RM_ARRAY;
         state_d = ST_IDLE;
      end else if (wr_stb && !busy) begin
         unique case (state_q)
            ST_IDLE: begin
               if (susp_q && wr_data == D_BLOCK) begin
                  valid_d = 1'b1;
                  op_d    = OP_RESUME;
                  addr_d  = wr_addr;
                  data_d  = wr_data;
                  susp_d  = 1'b0;
                  rmode_d = RM_STATUS;
               end else if (wr_data == D_UNLOCK_A && code_hit[0]) begin
                  state_d = ST_UNL1;
               end else begin
                  rmode_d = RM_ARRAY;
               end
            end
            ST_UNL1: begin
               if (wr_data == D_UNLOCK_B && code_hit[1]) state_d = ST_UNL2;
               else begin
                  state_d = ST_IDLE;
                  rmode_d = RM_ARRAY;
               end
            end
            ST_UNL2: begin
               state_d = ST_IDLE;
               if (!code_hit[0]) rmode_d = RM_ARRAY;
               else if (wr_data == D_RESET) begin
                  valid_d = 1'b1;
                  op_d    = OP_RESET;
                  addr_d  = wr_addr;
                  data_d  = wr_data;
                  rmode_d = RM_ARRAY;
               end else if (wr_data == D_AUTOSEL) begin
                  rmode_d = RM_SIGNATURE;
               end else if (wr_data == D_PROGRAM) begin
                  state_d = ST_PROG;
               end else if (wr_data == D_ERASE && !act_q) begin
                  state_d = ST_ER1;
               end else begin
                  rmode_d = RM_ARRAY;
               end
            end
            ST_PROG: begin
               valid_d = 1'b1;
               op_d    = OP_PROGRAM;
               addr_d  = wr_addr;
               data_d  = wr_data;
               rmode_d = RM_STATUS;
               state_d = ST_IDLE;
            end
            ST_ER1: begin
               if (wr_data == D_UNLOCK_A && code_hit[0]) state_d = ST_ER2;
               else begin
                  state_d = ST_IDLE;
                  rmode_d = RM_ARRAY;
               end
            end
            ST_ER2: begin
               if (wr_data == D_UNLOCK_B && code_hit[1]) state_d = ST_ER3;
               else begin
                  state_d = ST_IDLE;
                  rmode_d = RM_ARRAY;
               end
            end
            ST_ER3: begin
               state_d = ST_IDLE;
               if (wr_data == D_CHIP && code_hit[0]) begin
                  valid_d = 1'b1;
                  op_d    = OP_CHIP_ERASE;
                  addr_d  = wr_addr;
                  data_d  = wr_data;
                  act_d   = 1'b1;
                  rmode_d = RM_STATUS;
               end else if (wr_data == D_BLOCK) begin
                  valid_d  = 1'b1;
                  op_d     = OP_BLOCK_ADD;
                  addr_d   = wr_addr;
                  data_d   = wr_data;
                  win_load = 1'b1;
                  rmode_d  = RM_STATUS;
                  state_d  = ST_WIN;
               end else begin
                  rmode_d = RM_ARRAY;
               end
            end
            ST_WIN: begin
               if (wr_data == D_BLOCK) begin
                  valid_d  = 1'b1;
                  op_d     = OP_BLOCK_ADD;
                  addr_d   = wr_addr;
                  data_d   = wr_data;
                  win_load = 1'b1;
                  state_d  = ST_WIN;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rmode_q <= RM_ARRAY;
         op_q    <= OP_NONE;
         valid_q <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
         act_q   <= 1'b0;
         susp_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         rmode_q <= rmode_d;
         op_q    <= op_d;
         valid_q <= valid_d;
         addr_q  <= addr_d;
         data_q  <= data_d;
         act_q   <= act_d;
         susp_q  <= susp_d;
      end
   end

   assign cmd_valid       = valid_q;
   assign cmd_op          = op_q;
   assign cmd_addr        = addr_q;
   assign cmd_data        = data_q;
   assign read_mode       = rmode_q;
   assign timer_expired   = !win_active;
   assign erase_suspended = susp_q;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_stb,
   input logic       busy,
   input logic       erase_done,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic [1:0] read_mode,
   input logic       timer_expired,
   input logic       erase_suspended
);

   assert_op_coded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_op != 3'd0);

   assert_prog_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd2) |-> read_mode == 2'd2);

   assert_chip_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd3) |-> read_mode == 2'd2);

   assert_block_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd4) |-> !timer_expired);

   assert_start_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd5) |-> timer_expired);

   assert_busy_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && $past(wr_stb) && cmd_valid) |-> (cmd_op == 3'd6 || cmd_op == 3'd5));

   assert_suspend_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd6) |-> (erase_suspended && read_mode == 2'd0));

   assert_resume_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd7) |-> !erase_suspended);

   assert_done_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_done && !wr_stb) |=> !erase_suspended);

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_stb         (wr_stb),
   .busy           (busy),
   .erase_done     (erase_done),
   .cmd_valid      (cmd_valid),
   .cmd_op         (cmd_op),
   .read_mode      (read_mode),
   .timer_expired  (timer_expired),
   .erase_suspended(erase_suspended)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

   localparam int AW  = 19;
   localparam int WIN = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          byte_mode = 1'b0;
   logic          busy = 1'b0;
   logic          erase_done = 1'b0;
   logic          cmd_valid;
   logic [2:0]    cmd_op;
   logic [AW-1:0] cmd_addr;
   logic [7:0]    cmd_data;
   logic [1:0]    read_mode;
   logic          timer_expired;
   logic          erase_suspended;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [2:0]    q_op[$];
   logic [AW-1:0] q_addr[$];
   logic [7:0]    q_data[$];
   string         q_tag[$];

   always #2 clk = ~clk;

   flash_cmd_decoder #(.ADDR_W(AW), .ERASE_WIN_CYC(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .byte_mode(byte_mode), .busy(busy),
      .erase_done(erase_done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .read_mode(read_mode),
      .timer_expired(timer_expired), .erase_suspended(erase_suspended)
   );

   task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                             input logic [7:0] d, input string tag);
      q_op.push_back(op);
      q_addr.push_back(a);
      q_data.push_back(d);
      q_tag.push_back(tag);
   endtask

   // monitor: scoreboard for command pulses
   always @(negedge clk) begin
      if (rst_n && cmd_valid) begin
         checks++;
         if (q_op.size() == 0) begin
            errors++;
            $display("FAIL unexpected command: actual op=%0d addr=%0h expected none", cmd_op, cmd_addr);
         end else begin
            logic [2:0]    eo;
            logic [AW-1:0] ea;
            logic [7:0]    ed;
            string         et;
            eo = q_op.pop_front();
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            et = q_tag.pop_front();
            if (cmd_op !== eo || cmd_addr !== ea || cmd_data !== ed) begin
               errors++;
               $display("FAIL %s: actual op=%0d addr=%0h data=%0h expected op=%0d addr=%0h data=%0h",
                        et, cmd_op, cmd_addr, cmd_data, eo, ea, ed);
            end
         end
      end
   end

   task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic unlock();
      do_write(byte_mode ? 19'h0AAAA : 19'h05555, 8'hAA);
      do_write(byte_mode ? 19'h05555 : 19'h02AAA, 8'h55);
   endtask

   task automatic erase_prefix();
      unlock();
      do_write(19'h05555, 8'h80);
      unlock();
   endtask

   task automatic pulse_done();
      @(negedge clk);
      erase_done = 1'b1;
      @(negedge clk);
      erase_done = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 read_mode", read_mode, 0);
      check_eq("R1 cmd_valid", cmd_valid, 0);
      check_eq("R1 timer_expired", timer_expired, 1);
      check_eq("R1 suspended", erase_suspended, 0);

      // R4 signature mode, word addresses
      unlock();
      do_write(19'h05555, 8'h90);
      check_eq("R4 signature mode", read_mode, 1);

      // R3 read/reset
      unlock();
      expect_cmd(3'd1, 19'h05555, 8'hF0, "R3 reset cmd");
      do_write(19'h05555, 8'hF0);
      check_eq("R3 array mode", read_mode, 0);

      // R5 program
      unlock();
      do_write(19'h05555, 8'hA0);
      expect_cmd(3'd2, 19'h12345, 8'h5A, "R5 program cmd");
      do_write(19'h12345, 8'h5A);
      check_eq("R5 status mode", read_mode, 2);

      // R2 byte mode codes with high bits set
      byte_mode = 1'b1;
      do_write(19'h3AAAA, 8'hAA);
      do_write(19'h75555, 8'h55);
      do_write(19'h4AAAA, 8'h90);
      check_eq("R2 byte codes accepted", read_mode, 1);
      // R2/R8 word-mode address rejected in byte mode
      do_write(19'h05555, 8'hAA);
      check_eq("R2 wrong byte address", read_mode, 0);
      byte_mode = 1'b0;

      // R8 wrong second address, then restart works
      unlock();
      do_write(19'h05555, 8'h90);
      do_write(19'h05555, 8'hAA);
      do_write(19'h05555, 8'h55);
      check_eq("R8 bad unlock address", read_mode, 0);
      unlock();
      do_write(19'h05555, 8'h90);
      do_write(19'h05555, 8'hAA);
      do_write(19'h02AAA, 8'h55);
      do_write(19'h05555, 8'h77);
      check_eq("R8 bad command data", read_mode, 0);
      unlock();
      expect_cmd(3'd1, 19'h05555, 8'hF0, "R8 restart after error");
      do_write(19'h05555, 8'hF0);

      // R6 chip erase
      erase_prefix();
      expect_cmd(3'd3, 19'h05555, 8'h10, "R6 chip erase cmd");
      do_write(19'h05555, 8'h10);
      check_eq("R6 status mode", read_mode, 2);

      // R9 busy ignores writes
      busy = 1'b1;
      unlock();
      do_write(19'h05555, 8'hF0);
      check_eq("R9 busy keeps mode", read_mode, 2);

      // R10 suspend while busy
      expect_cmd(3'd6, 19'h00123, 8'hB0, "R10 suspend cmd");
      do_write(19'h00123, 8'hB0);
      check_eq("R10 suspended", erase_suspended, 1);
      check_eq("R10 array mode", read_mode, 0);
      busy = 1'b0;

      // R11 program during suspend then resume
      unlock();
      do_write(19'h05555, 8'hA0);
      expect_cmd(3'd2, 19'h6000F, 8'hC3, "R11 program in suspend");
      do_write(19'h6000F, 8'hC3);
      expect_cmd(3'd7, 19'h40000, 8'h30, "R11 resume cmd");
      do_write(19'h40000, 8'h30);
      check_eq("R11 not suspended", erase_suspended, 0);
      check_eq("R11 status mode", read_mode, 2);

      // R12 erase done, then B0h invalid
      pulse_done();
      do_write(19'h00000, 8'hB0);
      check_eq("R12 B0 invalid after done", read_mode, 0);
      check_eq("R12 no suspend", erase_suspended, 0);

      // R7 block erase with window
      erase_prefix();
      expect_cmd(3'd4, 19'h10000, 8'h30, "R7 first block");
      do_write(19'h10000, 8'h30);
      check_eq("R7 window open", timer_expired, 0);
      do_write(19'h00000, 8'h77);
      check_eq("R7 other write ignored", timer_expired, 0);
      repeat (3) @(negedge clk);
      expect_cmd(3'd4, 19'h20000, 8'h30, "R7 second block");
      do_write(19'h20000, 8'h30);
      expect_cmd(3'd5, 19'h20000, 8'h30, "R7 erase start");
      repeat (WIN - 1) @(negedge clk);
      check_eq("R7 window still open", timer_expired, 0);
      check_eq("R7 no early start", cmd_valid, 0);
      @(negedge clk);
      check_eq("R7 start on time", cmd_valid, 1);
      check_eq("R7 window closed", timer_expired, 1);

      // R10 suspend the block erase, R12 done clears it
      expect_cmd(3'd6, 19'h20004, 8'hB0, "R10 suspend block erase");
      do_write(19'h20004, 8'hB0);
      check_eq("R10 suspended again", erase_suspended, 1);
      pulse_done();
      check_eq("R12 done clears suspend", erase_suspended, 0);

      repeat (2) @(negedge clk);
      check_eq("R3 scoreboard drained", q_op.size(), 0);
      finished = 1'b1;
      finish_run();
   end

endmodule